// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Packed Condition Flags

This block holds an 8-bit accumulator and an 8-bit condition byte. On each clock edge where the valid strobe is high, it combines the accumulator with an operand byte according to a 3-bit operation code. The result goes back into the accumulator. In the same edge, five condition bits are rebuilt from the operation: sign, zero, nibble carry, even parity and carry/borrow.

The accumulator and the condition byte are both brought out. They are also presented as one 16-bit status word, which a surrounding datapath can save or inspect as a single value. The two add-through-carry operations and the two subtract-through-borrow operations take their incoming carry or borrow from the carry bit the previous operation left. This allows multi-byte arithmetic to be chained one byte per cycle.

Top module: `alu8_status_unit`

## Requirements
- R1: A synchronous reset (`rst_i` high at a rising edge) clears the accumulator and the condition byte, so `status_o` reads 0x0000 one edge later.
- R2: When `valid_i` is low, or when the operation code is 7 (reserved), the accumulator and the condition byte keep their values whatever the operand.
- R3: Operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 OR, 6 XOR. The 8-bit result replaces the accumulator at the edge where `valid_i` is sampled high.
- R4: The sign bit (condition bit 7) equals bit 7 of the new result.
- R5: The zero bit (condition bit 6) is 1 exactly when the new result is 0x00.
- R6: The nibble-carry bit (condition bit 4) has three cases:
  - For adds, it is the carry out of bit 3.
  - For subtracts, it is the borrow into bit 4, meaning the low nibble of the accumulator is less than the low nibble of the operand plus any incoming borrow.
  - For logical operations, it is 0.
- R7: The parity bit (condition bit 2) is 1 when the new result has an even number of set bits and 0 when the count is odd.
- R8: The carry bit (condition bit 0) has three cases:
  - For adds, it is the carry out of bit 7.
  - For subtracts, it is 1 on a borrow, meaning the accumulator is less than the operand plus any incoming borrow.
  - For logical operations, it is 0.
- R9: Condition bits 5, 3 and 1 always read 0.
- R10: `status_o` equals `{acc_o, flags_o}`: the accumulator is in bits 15..8 and the condition byte is in bits 7..0.
- R11: With the accumulator at 0x3F, adding 0x45 gives a status word of 0x8494 (result 0x84; sign 1, zero 0, nibble carry 1, parity 1, carry 0).
- R12: Add with carry adds the current carry bit as a carry-in. Subtract with borrow subtracts the current carry bit as a borrow-in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Perform the operation on this edge |
| opcode_i | input | 3 | Operation code |
| operand_i | input | 8 | Second operand byte |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 8 | Condition byte |
| status_o | output | 16 | Accumulator and condition byte combined |

## Verification
Two things fall in the same cycle: the carry bit is read as the carry-in or borrow-in of an operation, and that same operation writes a new carry bit. This is provoked by long runs of back-to-back valid cycles mixing add-with-carry and subtract-with-borrow, with no idle cycle between them, plus a directed carry chain after a wrap-around add. Each result is judged against a bench model that uses integer arithmetic and carries its own copy of the carry forward. Every operation code is also swept over all operand values against a spread of accumulator values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SBB  = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_NONE = 3'd7
    } alu_op_e;

    localparam int BIT_SIGN   = 7;
    localparam int BIT_ZERO   = 6;
    localparam int BIT_NIBCY  = 4;
    localparam int BIT_PARITY = 2;
    localparam int BIT_CARRY  = 0;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] flags;
    } alu_state_t;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = DATA_W,
    parameter int N = NIB_W
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cy_o,
    output logic         nib_o
);
    logic [W:0] wide_add, wide_sub;
    logic [N:0] nib_add, nib_sub;
    logic       cbit;

    always_comb begin
        cbit = ((op_i == OP_ADC) || (op_i == OP_SBB)) ? cin_i : 1'b0;
        wide_add = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cbit};
        wide_sub = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cbit};
        nib_add  = {1'b0, a_i[N-1:0]} + {1'b0, b_i[N-1:0]} + {{N{1'b0}}, cbit};
        nib_sub  = {1'b0, a_i[N-1:0]} - {1'b0, b_i[N-1:0]} - {{N{1'b0}}, cbit};
        res_o = '0;
        cy_o  = 1'b0;
        nib_o = 1'b0;
        unique case (op_i)
            OP_ADD, OP_ADC: begin
                res_o = wide_add[W-1:0];
                cy_o  = wide_add[W];
                nib_o = nib_add[N];
            end
            OP_SUB, OP_SBB: begin
                res_o = wide_sub[W-1:0];
                cy_o  = wide_sub[W];
                nib_o = nib_sub[N];
            end
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack
    import alu8_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] res_i,
    input  logic         cy_i,
    input  logic         nib_i,
    output logic [W-1:0] flags_o
);
    always_comb begin
        flags_o             = '0;
        flags_o[BIT_SIGN]   = res_i[W-1];
        flags_o[BIT_ZERO]   = (res_i == '0);
        flags_o[BIT_NIBCY]  = nib_i;
        flags_o[BIT_PARITY] = ~^res_i;
        flags_o[BIT_CARRY]  = cy_i;
    end
endmodule

// File: rtl/alu8_status_unit.sv
module alu8_status_unit
    import alu8_pkg::*;
(
    input  logic                  clk_i,
    input  logic                  rst_i,
    input  logic                  valid_i,
    input  logic [2:0]            opcode_i,
    input  logic [DATA_W-1:0]     operand_i,
    output logic [DATA_W-1:0]     acc_o,
    output logic [DATA_W-1:0]     flags_o,
    output logic [2*DATA_W-1:0]   status_o
);
    alu_state_t        st_d, st_q;
    alu_op_e           op;
    logic [DATA_W-1:0] res, new_flags;
    logic              res_cy, res_nib;

    assign op = alu_op_e'(opcode_i);

    alu8_arith u_arith (
        .op_i  (op),
        .a_i   (st_q.acc),
        .b_i   (operand_i),
        .cin_i (st_q.flags[BIT_CARRY]),
        .res_o (res),
        .cy_o  (res_cy),
        .nib_o (res_nib)
    );

    alu8_flagpack u_pack (
        .res_i   (res),
        .cy_i    (res_cy),
        .nib_i   (res_nib),
        .flags_o (new_flags)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i && (op != OP_NONE)) begin
            st_d.acc   = res;
            st_d.flags = new_flags;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign acc_o    = st_q.acc;
    assign flags_o  = st_q.flags;
    assign status_o = {st_q.acc, st_q.flags};

    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> (status_o == '0)); // R1
    AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!valid_i || opcode_i == 3'd7) |=> ($stable(acc_o) && $stable(flags_o))); // R2
    AST_SIGN_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && opcode_i != 3'd7) |=> (flags_o[7] == acc_o[7])); // R4
    AST_ZERO_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && opcode_i != 3'd7) |=> (flags_o[6] == (acc_o == '0))); // R5
    AST_PARITY_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && opcode_i != 3'd7) |=> (flags_o[2] == ~^acc_o)); // R7
    AST_LOGIC_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        (valid_i && opcode_i[2] && opcode_i != 3'd7) |=> (!flags_o[0] && !flags_o[4])); // R8
    AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_i |=> (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b0)); // R9
endmodule

// File: tb/alu8_status_unit_test.sv
`timescale 1ns/1ps
module alu8_status_unit_test;
    logic        clk = 1'b0;
    logic        rst_i = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  opcode_i = 3'd0;
    logic [7:0]  operand_i = 8'd0;
    logic [7:0]  acc_o, flags_o;
    logic [15:0] status_o;

    int total = 0;
    int bad = 0;
    int m_acc = 0;
    int m_flg = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    alu8_status_unit uut (
        .clk_i(clk), .rst_i(rst_i), .valid_i(valid_i), .opcode_i(opcode_i),
        .operand_i(operand_i), .acc_o(acc_o), .flags_o(flags_o), .status_o(status_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input int v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += (v >> i) & 1;
        return c;
    endfunction

    task automatic model(input int op);
        int a, b, cin, r, cy, nib;
        a = m_acc; b = int'(operand_i); cin = m_flg & 1;
        cy = 0; nib = 0; r = a;
        if (op == 7) return;
        case (op)
            0, 1: begin
                if (op == 0) cin = 0;
                r = a + b + cin; cy = (r > 255); nib = ((a & 15) + (b & 15) + cin) > 15;
            end
            2, 3: begin
                if (op == 2) cin = 0;
                r = a - b - cin; cy = (r < 0); nib = ((a & 15) - (b & 15) - cin) < 0;
            end
            4: r = a & b;
            5: r = a | b;
            default: r = a ^ b;
        endcase
        r = r & 255;
        m_acc = r;
        m_flg = (((r >> 7) & 1) << 7) | ((r == 0) << 6) | (nib << 4)
              | (((ones(r) % 2) == 0) << 2) | cy;
    endtask

    task automatic run_op(input int op, input int b, input string tag);
        valid_i = 1'b1; opcode_i = 3'(op); operand_i = 8'(b);
        model(op);
        @(negedge clk);
        valid_i = 1'b0;
        check(tag, int'(status_o), (m_acc << 8) | m_flg);
    endtask

    task automatic load_acc(input int v);
        run_op(4, 0, "R3 R8 clear AND");
        run_op(5, v, "R3 R9 load OR");
    endtask

    task automatic do_reset();
        rst_i = 1'b1; valid_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_i = 1'b0; m_acc = 0; m_flg = 0;
        check("R1 reset status", int'(status_o), 0);
    endtask

    initial begin
        repeat (160000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int lf;
        do_reset();

        // R11 worked example
        load_acc(8'h3F);
        run_op(0, 8'h45, "R11 R4 R5 R6 R7 R8");
        check("R11 exact status", int'(status_o), 16'h8494);
        check("R10 status high byte", int'(status_o[15:8]), int'(acc_o));
        check("R10 status low byte", int'(status_o[7:0]), int'(flags_o));

        // R2 idle and reserved opcode
        for (int op = 0; op < 8; op++) begin
            valid_i = 1'b0; opcode_i = 3'(op); operand_i = 8'hA5;
            @(negedge clk);
            check("R2 valid low hold", int'(status_o), (m_acc << 8) | m_flg);
        end
        run_op(7, 8'hFF, "R2 reserved opcode hold");

        // R12 carry chain: 0x01 + 0xFF wraps, then ADC picks up carry
        load_acc(8'h01);
        run_op(0, 8'hFF, "R8 R5 wrap add");
        check("R8 carry set", int'(flags_o[0]), 1);
        run_op(1, 8'h00, "R12 adc carry-in");
        check("R12 adc result", int'(acc_o), 1);
        run_op(2, 8'h02, "R8 R6 borrow sub");
        check("R8 borrow set", int'(flags_o[0]), 1);
        run_op(3, 8'h00, "R12 sbb borrow-in");
        check("R12 sbb result", int'(acc_o), 8'hFE);

        // sweep: every op, all operands, spread of accumulators
        for (int op = 0; op < 7; op++)
            for (int a = 0; a < 256; a += 15)
                for (int b = 0; b < 256; b++) begin
                    load_acc(a);
                    run_op(op, b, "R3 R4 R5 R6 R7 R8 R9 sweep");
                end

        // back-to-back chained ops
        lf = 32'h1ACE;
        for (int i = 0; i < 4000; i++) begin
            lf = (lf >> 1) ^ ((lf & 1) ? 32'hB400 : 0);
            run_op((lf & 7) == 7 ? 1 : (lf & 7), (lf >> 3) & 255, "R12 R3 chained");
        end

        // reset after activity
        load_acc(8'h77);
        do_reset();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule